// File: doc/BRIEF.md
# Multimode Timer Bank

A bank of independent counters, three by default, each owning one bidirectional pin that appears at the ports as an input, an output and an output enable. Each counter is set by a small configuration field to one of three jobs. It can drive a periodic rectangular waveform, measure the high time and the period of a signal on its pin, or count pulses on its pin and raise a flag once a programmed number has arrived.

Software uses a simple single-cycle register bus, and reads return the selected register combinationally. One shared register holds a run bit for each counter and the event flags, which are cleared by writing ones. Each counter's interrupt line is its flag gated by the counter's interrupt-enable bit.

Top module: `gp_timer_bank`

## Requirements
- R1: After reset every register reads zero, no pin is driven (`pin_oe_o` low, `pin_o` low) and every `irq_o` bit is low.
- R2: Address 0 is the shared register. Counter k (from 0) owns address 4*(k+1)+f, with f=0 for configuration, 1 for count, 2 for period and 3 for width. Configuration bits [1:0] select the mode (0 waveform, 1 capture, 2 event watchdog, 3 hold), bit 2 is the polarity and bit 3 the interrupt enable. Written values read back, and addresses 1 to 3 read zero.
- R3: In the shared register, bits [2:0] are the run bits, written directly, and bits [5:3] are the event flags of counters 0 to 2. Writing a one to a flag bit clears it, but an event in the same cycle leaves the flag set.
- R4: In waveform mode a running counter drives its pin (`pin_oe_o`=1) with `pin_o` = (count < width) XOR polarity.
- R5: In waveform mode, when the count is at or above the period, the next count is 0 and the counter's flag is set. Otherwise the count rises by 1 each cycle.
- R6: In capture mode the pin passes through a two-stage synchronizer. A rising edge at the synchronizer output copies the count into the period register, restarts the count at 0 and sets the flag. Otherwise the count rises by 1 each cycle.
- R7: In capture mode a falling edge at the synchronizer output copies the count into the width register.
- R8: In watchdog mode the count rises by 1 on each synchronized rising edge of the pin. On an edge where count+1 reaches or passes the period, the count goes to 0 and the flag is set.
- R9: A counter whose run bit is clear keeps its count and leaves its pin undriven.
- R10: `irq_o[k]` is high exactly when flag k is set and counter k's interrupt-enable bit is set. Flags are set whatever the enable says.
- R11: A bus write to a count, period or width register takes precedence over the hardware update of that register in the same cycle.
- R12: The polarity bit inverts the synchronized pin level before edge detection in capture and watchdog modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| pin_i | input | 3 | Pin levels seen from outside |
| pin_o | output | 3 | Pin drive values |
| pin_oe_o | output | 3 | Pin drive enables |
| irq_o | output | 3 | Interrupt request per counter |

## Verification
Two actions can land on the same clock edge: a counter's hardware event and software's write-one-to-clear of that flag, and likewise a bus write to a count register and the counter's own increment or reload. The bench tracks its model's count and places the clearing write on the exact edge where the waveform counter reloads. It then reads the shared register and expects the flag to have survived. It also writes a count while the counter runs and expects the written value, not the incremented one, on the next read. A behavioural model compares the pins, the interrupts and a rotating register read on every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_PWM  = 2'd0,
    MODE_CAP  = 2'd1,
    MODE_WDG  = 2'd2,
    MODE_HOLD = 2'd3
  } tmr_mode_e;

  localparam int CFG_POL_BIT = 2;
  localparam int CFG_IE_BIT  = 3;

  localparam logic [1:0] FLD_CFG = 2'd0;
  localparam logic [1:0] FLD_CNT = 2'd1;
  localparam logic [1:0] FLD_PER = 2'd2;
  localparam logic [1:0] FLD_WID = 2'd3;
endpackage

// File: rtl/tmr_edge.sv
module tmr_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic inv_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic lvl, prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= raw_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
    end
  endgenerate

  assign lvl = sync_q[SYNC_STAGES-1] ^ inv_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl;

  assign rise_o = lvl & ~prev_q;
  assign fall_o = ~lvl & prev_q;
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int CFG_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             wr_cfg_i,
  input  logic             wr_cnt_i,
  input  logic             wr_per_i,
  input  logic             wr_wid_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             pin_i,
  output logic             pin_o,
  output logic             pin_oe_o,
  output logic             ev_o,
  output logic [CFG_W-1:0] cfg_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] wid_o
);
  logic [CFG_W-1:0] cfg_q;
  logic [CNT_W-1:0] cnt_q, per_q, wid_q, cnt_d, per_d, wid_d;
  logic [CNT_W:0]   cnt_inc;
  logic             rise, fall, pol, ev;
  tmr_mode_e        mode;

  assign mode    = tmr_mode_e'(cfg_q[1:0]);
  assign pol     = cfg_q[CFG_POL_BIT];
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  tmr_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i (pin_i),
    .inv_i (pol),
    .rise_o(rise),
    .fall_o(fall)
  );

  always_comb begin
    cnt_d = cnt_q;
    per_d = per_q;
    wid_d = wid_q;
    ev    = 1'b0;
    if (en_i) begin
      unique case (mode)
        MODE_PWM: begin
          if (cnt_q >= per_q) begin
            cnt_d = '0;
            ev    = 1'b1;
          end else cnt_d = cnt_inc[CNT_W-1:0];
        end
        MODE_CAP: begin
          if (rise) begin
            per_d = cnt_q;
            cnt_d = '0;
            ev    = 1'b1;
          end else cnt_d = cnt_inc[CNT_W-1:0];
          if (fall) wid_d = cnt_q;
        end
        MODE_WDG: begin
          if (rise) begin
            if (cnt_inc >= {1'b0, per_q}) begin
              cnt_d = '0;
              ev    = 1'b1;
            end else cnt_d = cnt_inc[CNT_W-1:0];
          end
        end
        default: ;
      endcase
    end
    // bus beats hardware
    if (wr_cnt_i) cnt_d = wdata_i;
    if (wr_per_i) per_d = wdata_i;
    if (wr_wid_i) wid_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      cnt_q <= '0;
      per_q <= '0;
      wid_q <= '0;
    end else begin
      if (wr_cfg_i) cfg_q <= wdata_i[CFG_W-1:0];
      cnt_q <= cnt_d;
      per_q <= per_d;
      wid_q <= wid_d;
    end
  end

  assign pin_oe_o = en_i && (mode == MODE_PWM);
  assign pin_o    = pin_oe_o & ((cnt_q < wid_q) ^ pol);
  assign ev_o     = ev;
  assign cfg_o    = cfg_q;
  assign cnt_o    = cnt_q;
  assign per_o    = per_q;
  assign wid_o    = wid_q;

  p_pwm_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && mode == MODE_PWM && cnt_q >= per_q && !wr_cnt_i |=> cnt_q == '0);

  p_hold_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !wr_cnt_i |=> cnt_q == $past(cnt_q));

  p_cap_period_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && mode == MODE_CAP && rise && !wr_per_i |=> per_q == $past(cnt_q));

  p_cap_width_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && mode == MODE_CAP && fall && !wr_wid_i |=> wid_q == $past(cnt_q));
endmodule

// File: rtl/gp_timer_bank.sv
module gp_timer_bank
  import tmr_pkg::*;
#(
  parameter int N_TMR       = 3,
  parameter int CNT_W       = 32,
  parameter int CFG_W       = 6,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(N_TMR + 1) + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  input  logic [N_TMR-1:0]  pin_i,
  output logic [N_TMR-1:0]  pin_o,
  output logic [N_TMR-1:0]  pin_oe_o,
  output logic [N_TMR-1:0]  irq_o
);
  localparam int SEL_W = ADDR_W - 2;

  logic [N_TMR-1:0]            en_q, flag_q, ev, clr;
  logic [N_TMR-1:0][CFG_W-1:0] cfg;
  logic [N_TMR-1:0][CNT_W-1:0] cnt, per, wid;
  logic                        ctrl_wr;
  logic [SEL_W-1:0]            sel;
  logic [1:0]                  fld;

  assign sel     = bus_addr_i[ADDR_W-1:2];
  assign fld     = bus_addr_i[1:0];
  assign ctrl_wr = bus_we_i && sel == '0 && fld == 2'd0;
  assign clr     = ctrl_wr ? bus_wdata_i[2*N_TMR-1:N_TMR] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      if (ctrl_wr) en_q <= bus_wdata_i[N_TMR-1:0];
      flag_q <= (flag_q & ~clr) | ev;
    end
  end

  for (genvar k = 0; k < N_TMR; k++) begin : g_tmr
    logic hit;
    assign hit = bus_we_i && sel == SEL_W'(k + 1);

    tmr_unit #(
      .CNT_W      (CNT_W),
      .CFG_W      (CFG_W),
      .SYNC_STAGES(SYNC_STAGES)
    ) i_unit (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_q[k]),
      .wr_cfg_i(hit && fld == FLD_CFG),
      .wr_cnt_i(hit && fld == FLD_CNT),
      .wr_per_i(hit && fld == FLD_PER),
      .wr_wid_i(hit && fld == FLD_WID),
      .wdata_i (bus_wdata_i),
      .pin_i   (pin_i[k]),
      .pin_o   (pin_o[k]),
      .pin_oe_o(pin_oe_o[k]),
      .ev_o    (ev[k]),
      .cfg_o   (cfg[k]),
      .cnt_o   (cnt[k]),
      .per_o   (per[k]),
      .wid_o   (wid[k])
    );

    assign irq_o[k] = flag_q[k] & cfg[k][CFG_IE_BIT];

    p_flag_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev[k] |=> flag_q[k]);
  end

  always_comb begin
    bus_rdata_o = '0;
    if (sel == '0) begin
      if (fld == 2'd0) bus_rdata_o[2*N_TMR-1:0] = {flag_q, en_q};
    end else begin
      for (int k = 0; k < N_TMR; k++) begin
        if (sel == SEL_W'(k + 1)) begin
          unique case (fld)
            FLD_CFG: bus_rdata_o = CNT_W'(cfg[k]);
            FLD_CNT: bus_rdata_o = cnt[k];
            FLD_PER: bus_rdata_o = per[k];
            default: bus_rdata_o = wid[k];
          endcase
        end
      end
    end
  end

  p_undriven_when_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(|en_q) |-> pin_oe_o == '0);
endmodule

// File: tb/test_gp_timer_bank.sv
module test_gp_timer_bank;
  localparam int N = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [3:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [N-1:0] pin_i = '0, pin_o, pin_oe_o, irq_o;

  int total = 0, bad = 0, cyc = 0;
  bit idle_rot = 1'b1;
  string tag = "R1";

  always #5 clk_i = ~clk_i;

  gp_timer_bank i_gp_timer_bank (.*);

  // behavioural model
  logic [31:0] m_cnt[N], m_per[N], m_wid[N];
  logic [5:0]  m_cfg[N];
  logic        m_en[N], m_flag[N], m_s1[N], m_s2[N], m_prev[N];

  initial for (int k = 0; k < N; k++) begin
    m_cnt[k] = 0; m_per[k] = 0; m_wid[k] = 0; m_cfg[k] = 0;
    m_en[k] = 0; m_flag[k] = 0; m_s1[k] = 0; m_s2[k] = 0; m_prev[k] = 0;
  end

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N; k++) begin
        m_cnt[k] = 0; m_per[k] = 0; m_wid[k] = 0; m_cfg[k] = 0;
        m_en[k] = 0; m_flag[k] = 0; m_s1[k] = 0; m_s2[k] = 0; m_prev[k] = 0;
      end
    end else begin
      for (int k = 0; k < N; k++) begin
        logic lvl, rise, fall, ev;
        logic [31:0] nc, np, nw;
        longint inc;
        int base;
        lvl = m_s2[k] ^ m_cfg[k][2];
        rise = lvl && !m_prev[k];
        fall = !lvl && m_prev[k];
        ev = 0; nc = m_cnt[k]; np = m_per[k]; nw = m_wid[k];
        inc = longint'(m_cnt[k]) + 1;
        if (m_en[k]) begin
          case (m_cfg[k][1:0])
            2'd0: if (m_cnt[k] >= m_per[k]) begin nc = 0; ev = 1; end else nc = m_cnt[k] + 1;
            2'd1: begin
              if (rise) begin np = m_cnt[k]; nc = 0; ev = 1; end else nc = m_cnt[k] + 1;
              if (fall) nw = m_cnt[k];
            end
            2'd2: if (rise) begin
              if (inc >= longint'(m_per[k])) begin nc = 0; ev = 1; end else nc = m_cnt[k] + 1;
            end
            default: ;
          endcase
        end
        base = 4 * (k + 1);
        if (bus_we_i) begin
          if (bus_addr_i == base)     m_cfg[k] = bus_wdata_i[5:0];
          if (bus_addr_i == base + 1) nc = bus_wdata_i;
          if (bus_addr_i == base + 2) np = bus_wdata_i;
          if (bus_addr_i == base + 3) nw = bus_wdata_i;
        end
        m_cnt[k] = nc; m_per[k] = np; m_wid[k] = nw;
        if (bus_we_i && bus_addr_i == 0) begin
          if (bus_wdata_i[N + k]) m_flag[k] = 0;
          m_en[k] = bus_wdata_i[k];
        end
        if (ev) m_flag[k] = 1;
        m_s2[k] = m_s1[k];
        m_s1[k] = pin_i[k];
        m_prev[k] = lvl;
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [3:0] a);
    int k;
    logic [31:0] r;
    r = 0;
    if (a == 0) begin
      for (int j = 0; j < N; j++) begin r[j] = m_en[j]; r[N + j] = m_flag[j]; end
    end else if (a >= 4) begin
      k = a / 4 - 1;
      case (a % 4)
        0: r = {26'd0, m_cfg[k]};
        1: r = m_cnt[k];
        2: r = m_per[k];
        default: r = m_wid[k];
      endcase
    end
    return r;
  endfunction

  task automatic chk(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at cycle %0d", t, what, act, exp, cyc);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk_i) begin
    logic [N-1:0] eo, eoe, eirq;
    cyc++;
    for (int k = 0; k < N; k++) begin
      eoe[k] = m_en[k] && m_cfg[k][1:0] == 2'd0;
      eo[k]  = eoe[k] && ((m_cnt[k] < m_wid[k]) ^ m_cfg[k][2]);
      eirq[k] = m_flag[k] && m_cfg[k][3];
    end
    chk(tag, "pin_oe", 32'(pin_oe_o), 32'(eoe));
    chk(tag, "pin_o", 32'(pin_o), 32'(eo));
    chk(tag, "irq R10", 32'(irq_o), 32'(eirq));
    chk(tag, "rdata", bus_rdata_o, m_read(bus_addr_i));
  end

  // pin stimulus and idle read rotation
  always @(negedge clk_i) begin
    #1;
    pin_i[0] <= (cyc % 3) == 0;
    pin_i[1] <= (cyc % 13) < 5;
    pin_i[2] <= (cyc % 6) < 2;
    if (idle_rot && !bus_we_i) bus_addr_i <= 4'(cyc);
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i); #1;
    idle_rot = 0;
    bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i); #1;
    bus_we_i = 0;
    idle_rot = 1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #1 rst_ni = 1;
    tag = "R1";
    @(negedge clk_i);
    chk("R1", "irq after reset", 32'(irq_o), 0);
    chk("R1", "oe after reset", 32'(pin_oe_o), 0);
    idle(16);

    tag = "R2";
    wr(4, 32'h08); wr(6, 9); wr(7, 3);
    wr(8, 32'h09);
    wr(12, 32'h0A); wr(14, 4);
    wr(1, 32'hFFFF);
    idle(16);

    tag = "R3"; wr(0, 32'h7);
    tag = "R4"; idle(30);
    tag = "R5"; idle(30);
    tag = "R6"; idle(40);
    tag = "R7"; idle(40);
    tag = "R8"; idle(60);
    tag = "R10"; wr(12, 32'h02); idle(40);

    tag = "R3";
    wr(0, 32'h3F);
    idle(4);
    // collision: clear flag 0 on the edge where counter 0 reloads
    do @(negedge clk_i); while (m_cnt[0] != 9);
    #1 idle_rot = 0; bus_we_i = 1; bus_addr_i = 0; bus_wdata_i = 32'h0F;
    @(negedge clk_i);
    chk("R3", "flag0 kept on collision", 32'(bus_rdata_o[3]), 1);
    #1 bus_we_i = 0; idle_rot = 1;
    idle(8);

    tag = "R11";
    @(negedge clk_i); #1 idle_rot = 0; bus_we_i = 1; bus_addr_i = 5; bus_wdata_i = 2;
    @(negedge clk_i);
    chk("R11", "count write wins", bus_rdata_o, 2);
    #1 bus_we_i = 0; idle_rot = 1;
    idle(20);

    tag = "R12"; wr(8, 32'h0D); idle(50);
    tag = "R4"; wr(4, 32'h0C); idle(30);

    tag = "R9"; wr(0, 32'h0);
    @(negedge clk_i);
    chk("R9", "pins undriven when stopped", 32'(pin_oe_o), 0);
    idle(20);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule